// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block is a single receive channel for ARINC 429-style serial words. It takes two logic-level rails, one pulsing for a 1 bit and the other for a 0 bit, that an external line receiver has already translated from the differential bus. A loop-back pair carrying the transmitter's own rails can be selected in place of the line. The rails are sampled at ten times the bit rate. A bit counts only when its pulse is still present two sampling periods after its start was seen. Words of 32 or 25 bits are assembled, and a word is accepted only when a full bit time of null comes before it and after it.

An accepted word can optionally be filtered on its source/destination code. Its parity is checked, and it is held in a single buffer that new words never overwrite. A host reads the buffer as two 16-bit halves: it sets `sel` and pulses `rd_n` low. `dr_n` goes low while a word waits and rises at the leading edge of the strobe that completes reading both halves. The mode inputs come from a control register outside this block, and reset does not touch them.

Top module: `a429_rx_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied and `dr_n` reads 1 from the next cycle on. This also applies when a word is waiting.
- R2: In 32-bit mode, serial bit k (first bit k=1) is word bit w[k-1]. Half 1 (`sel`=0) is {w[14:8], parity flag, w[7:0]}, so the label sits in bits 7:0. Half 2 (`sel`=1) is w[30:15]. Serial bit 32 enters only the parity flag.
- R3: In 25-bit mode (`short_word`=1), a word completes after 25 bits. It uses the same mapping with w[31:25]=0, so half 2 carries serial bits 16 to 25 in its bits 9:0 and zeros above.
- R4: Bit 8 of half 1 is 0 when the received bits hold an odd number of ones and 1 when they hold an even number.
- R5: With `sd_en`=1, a word is latched only if serial bit 9 equals `sd_x` and serial bit 10 equals `sd_y`. Otherwise it is dropped and `dr_n` stays 1.
- R6: A word whose first bit starts less than one bit time (10 sampling periods) of null after earlier rail activity is discarded.
- R7: A word that stops before its last bit, with no new bit starting within 12 sampling periods of the previous one, is discarded. The next well-framed word is received intact.
- R8: If a further bit starts before 20 sampling periods after the last bit of a word have passed, that word is discarded.
- R9: A bit start is confirmed two sampling periods after it is detected. A rail pulse shorter than that is rejected and adds no bit.
- R10: `dr_n` rises at the first clock edge that sees `rd_n` low for the strobe that completes both halves. Reading the same half again does not clear it.
- R11: While `dr_n` is 0, a newly received word is dropped and the buffered word is returned unchanged.
- R12: With `lo_speed`=1 the sampling period is 8 clocks instead of 1, and words at one eighth of the rate are received.
- R13: With `selftest`=1 the loop-back rails replace the line rails. When `INVERT_WRAP`=1 the loop-back rails are swapped, so every received bit is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, ten times the high bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_hi | input | 1 | Line rail that pulses for a 1 bit |
| line_lo | input | 1 | Line rail that pulses for a 0 bit |
| wrap_hi | input | 1 | Loop-back rail for a 1 bit |
| wrap_lo | input | 1 | Loop-back rail for a 0 bit |
| selftest | input | 1 | 1 selects the loop-back rails |
| lo_speed | input | 1 | 1 selects the low bit rate (sampling every 8 clocks) |
| short_word | input | 1 | 1 selects 25-bit words |
| sd_en | input | 1 | Enables the source/destination filter |
| sd_x | input | 1 | Expected value of serial bit 9 |
| sd_y | input | 1 | Expected value of serial bit 10 |
| sel | input | 1 | Half select: 0 for half 1, 1 for half 2 |
| rd_n | input | 1 | Active-low read strobe |
| rd_data | output | 16 | Selected buffer half |
| dr_n | output | 1 | Active-low data ready |

## Verification
The hardest cases to reach from the ports are the framing rejects: a word begun too soon after activity, a word that stops early, a word with one bit too many, and a pulse too short to confirm. Each of these leaves no visible trace, so every one is followed by a well-framed word. Its exact contents show whether the rejected activity reset the receiver or leaked bits into the next word. The buffer-full case is reached by sending two words with no read between them and checking that the first word comes back.

// File: rtl/a429_rx_pkg.sv
`timescale 1ns/1ps
package a429_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_INWORD  = 2'd2
    } rx_state_e;

    localparam logic [1:0] RAIL_NULL = 2'b00;
    localparam logic [1:0] RAIL_BAD  = 2'b11;
endpackage

// File: rtl/a429_rx_tick.sv
`timescale 1ns/1ps
module a429_rx_tick #(
    parameter int LO_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_speed,
    output logic tick
);
    generate
        if (LO_DIV > 1) begin : g_div
            localparam int CW = $clog2(LO_DIV);
            localparam logic [CW-1:0] LAST = CW'(LO_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = !lo_speed || (cnt_q == '0);

            // R12: in low speed a sampling tick is never followed by another
            assert_lo_rate_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (lo_speed && tick) |=> (!tick || !lo_speed));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/a429_rx_input.sv
`timescale 1ns/1ps
module a429_rx_input #(
    parameter bit INVERT_WRAP = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_hi,
    input  logic       line_lo,
    input  logic       wrap_hi,
    input  logic       wrap_lo,
    input  logic       selftest,
    output logic [1:0] rails
);
    logic [1:0] wrap_pair;
    logic [1:0] rails_d, rails_q;

    generate
        if (INVERT_WRAP) begin : g_inv
            assign wrap_pair = {wrap_lo, wrap_hi};
        end else begin : g_pass
            assign wrap_pair = {wrap_hi, wrap_lo};
        end
    endgenerate

    always_comb begin
        rails_d = selftest ? wrap_pair : {line_hi, line_lo};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rails_q <= '0;
        else        rails_q <= rails_d;
    end

    assign rails = rails_q;
endmodule

// File: rtl/a429_rx_framer.sv
`timescale 1ns/1ps
module a429_rx_framer import a429_rx_pkg::*; #(
    parameter int FULL_BITS  = 32,
    parameter int SHORT_BITS = 25,
    parameter int OVS        = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [1:0]           rails,
    input  logic                 short_word,
    output logic                 out_valid,
    output logic [FULL_BITS-1:0] out_word
);
    localparam int CONFIRM_TICKS = 2;
    localparam int MIN_SPACE     = OVS - 2;
    localparam int MAX_SPACE     = OVS + 2;
    localparam int END_TICKS     = 2 * OVS;
    localparam int NULL_MIN      = OVS;
    localparam int CNT_W         = $clog2(END_TICKS + 1);
    localparam int BC_W          = $clog2(FULL_BITS + 1);
    localparam int SHIFT         = FULL_BITS - SHORT_BITS;

    typedef struct packed {
        rx_state_e            st;
        logic [1:0]           prev;
        logic [1:0]           val;
        logic [CNT_W-1:0]     ph;
        logic [CNT_W-1:0]     nrun;
        logic [BC_W-1:0]      nbits;
        logic [FULL_BITS-1:0] sr;
        logic                 done;
    } fr_t;

    fr_t st_d, st_q;
    logic             cur_null, start_edge;
    logic [BC_W-1:0]  len;
    logic [CNT_W-1:0] n;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        cur_null   = (rails == RAIL_NULL);
        start_edge = (st_q.prev == RAIL_NULL) && !cur_null;
        len        = short_word ? BC_W'(SHORT_BITS) : BC_W'(FULL_BITS);
        n          = (st_q.ph == CNT_W'(END_TICKS)) ? st_q.ph : st_q.ph + 1'b1;

        if (tick) begin
            st_d.prev = rails;
            case (st_q.st)
                ST_IDLE: begin
                    if (cur_null) begin
                        if (st_q.nrun < CNT_W'(NULL_MIN)) st_d.nrun = st_q.nrun + 1'b1;
                    end else if (start_edge && st_q.nrun >= CNT_W'(NULL_MIN)) begin
                        st_d.st    = ST_CONFIRM;
                        st_d.val   = rails;
                        st_d.ph    = '0;
                        st_d.nbits = '0;
                    end else begin
                        st_d.nrun = '0;
                    end
                end
                ST_CONFIRM: begin
                    st_d.ph = n;
                    if (n == CNT_W'(CONFIRM_TICKS)) begin
                        if (rails == st_q.val && st_q.val != RAIL_BAD) begin
                            st_d.sr    = {st_q.val[1], st_q.sr[FULL_BITS-1:1]};
                            st_d.nbits = st_q.nbits + 1'b1;
                            st_d.st    = ST_INWORD;
                        end else begin
                            st_d.st   = ST_IDLE;
                            st_d.nrun = '0;
                        end
                    end
                end
                ST_INWORD: begin
                    st_d.ph = n;
                    if (start_edge) begin
                        if (st_q.nbits < len && n >= CNT_W'(MIN_SPACE) && n <= CNT_W'(MAX_SPACE)) begin
                            st_d.st  = ST_CONFIRM;
                            st_d.val = rails;
                            st_d.ph  = '0;
                        end else begin
                            st_d.st   = ST_IDLE;
                            st_d.nrun = '0;
                        end
                    end else if (st_q.nbits < len && n > CNT_W'(MAX_SPACE)) begin
                        st_d.st   = ST_IDLE;
                        st_d.nrun = '0;
                    end else if (st_q.nbits == len && n == CNT_W'(END_TICKS)) begin
                        st_d.done = 1'b1;
                        st_d.st   = ST_IDLE;
                        st_d.nrun = CNT_W'(NULL_MIN);
                    end
                end
                default: st_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.done;
    assign out_word  = short_word ? (st_q.sr >> SHIFT) : st_q.sr;

    // R8: a completed word was closed by a null sample
    assert_trailing_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(rails) == RAIL_NULL));

    // R3: a word completes only with the bit count the word-length mode asks for
    assert_word_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.nbits == (short_word ? BC_W'(SHORT_BITS) : BC_W'(FULL_BITS))));
endmodule

// File: rtl/a429_rx_buffer.sv
`timescale 1ns/1ps
module a429_rx_buffer #(
    parameter int FULL_BITS = 32,
    parameter int HOST_W    = 16,
    parameter int LABEL_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FULL_BITS-1:0] in_word,
    input  logic                 sd_en,
    input  logic                 sd_x,
    input  logic                 sd_y,
    input  logic                 sel,
    input  logic                 rd_n,
    output logic [HOST_W-1:0]    rd_data,
    output logic                 dr_n
);
    localparam int SD_POS = LABEL_W;

    typedef struct packed {
        logic                 valid;
        logic                 got1;
        logic                 got2;
        logic                 rdn_prev;
        logic                 perr;
        logic [FULL_BITS-1:0] data;
    } buf_t;

    buf_t bs_d, bs_q;
    logic rd_fall, sd_ok;

    always_comb begin
        bs_d          = bs_q;
        bs_d.rdn_prev = rd_n;
        rd_fall       = bs_q.rdn_prev && !rd_n;
        sd_ok         = !sd_en || (in_word[SD_POS] == sd_x && in_word[SD_POS+1] == sd_y);

        if (bs_q.valid && rd_fall) begin
            if (sel) bs_d.got2 = 1'b1;
            else     bs_d.got1 = 1'b1;
            if ((sel && bs_q.got1) || (!sel && bs_q.got2)) begin
                bs_d.valid = 1'b0;
                bs_d.got1  = 1'b0;
                bs_d.got2  = 1'b0;
            end
        end

        if (in_valid && !bs_q.valid && sd_ok) begin
            bs_d.valid = 1'b1;
            bs_d.got1  = 1'b0;
            bs_d.got2  = 1'b0;
            bs_d.data  = in_word;
            bs_d.perr  = ~^in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '{rdn_prev: 1'b1, default: '0};
        else        bs_q <= bs_d;
    end

    assign rd_data = sel ? bs_q.data[2*HOST_W-2:HOST_W-1]
                         : {bs_q.data[HOST_W-2:LABEL_W], bs_q.perr, bs_q.data[LABEL_W-1:0]};
    assign dr_n    = !bs_q.valid;

    // R1: reset empties the buffer
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !bs_q.valid);

    // R11: a full buffer keeps its word when another arrives
    assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_q.valid && in_valid) |=> $stable(bs_q.data));

    // R10: a waiting word stays ready until a completing strobe edge
    assert_hold_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_q.valid && !rd_fall) |=> bs_q.valid);

    // R5: a word failing the code filter does not fill an empty buffer
    assert_sd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bs_q.valid && sd_en &&
         (in_word[SD_POS] != sd_x || in_word[SD_POS+1] != sd_y)) |=> !bs_q.valid);
endmodule

// File: rtl/a429_rx_channel.sv
`timescale 1ns/1ps
module a429_rx_channel #(
    parameter int FULL_BITS   = 32,
    parameter int SHORT_BITS  = 25,
    parameter int OVS         = 10,
    parameter int LO_DIV      = 8,
    parameter int HOST_W      = 16,
    parameter bit INVERT_WRAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_hi,
    input  logic              line_lo,
    input  logic              wrap_hi,
    input  logic              wrap_lo,
    input  logic              selftest,
    input  logic              lo_speed,
    input  logic              short_word,
    input  logic              sd_en,
    input  logic              sd_x,
    input  logic              sd_y,
    input  logic              sel,
    input  logic              rd_n,
    output logic [HOST_W-1:0] rd_data,
    output logic              dr_n
);
    logic                 tick;
    logic [1:0]           rails;
    logic                 word_valid;
    logic [FULL_BITS-1:0] word;

    a429_rx_tick #(.LO_DIV(LO_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .lo_speed(lo_speed), .tick(tick)
    );

    a429_rx_input #(.INVERT_WRAP(INVERT_WRAP)) u_input (
        .clk(clk), .rst_n(rst_n),
        .line_hi(line_hi), .line_lo(line_lo),
        .wrap_hi(wrap_hi), .wrap_lo(wrap_lo),
        .selftest(selftest), .rails(rails)
    );

    a429_rx_framer #(.FULL_BITS(FULL_BITS), .SHORT_BITS(SHORT_BITS), .OVS(OVS)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rails(rails),
        .short_word(short_word), .out_valid(word_valid), .out_word(word)
    );

    a429_rx_buffer #(.FULL_BITS(FULL_BITS), .HOST_W(HOST_W), .LABEL_W(8)) u_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(word_valid), .in_word(word),
        .sd_en(sd_en), .sd_x(sd_x), .sd_y(sd_y),
        .sel(sel), .rd_n(rd_n), .rd_data(rd_data), .dr_n(dr_n)
    );
endmodule

// File: tb/a429_rx_channel_test.sv
`timescale 1ns/1ps
module a429_rx_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int HI_HALF    = 5;
    localparam int LO_HALF    = 40;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, line_hi, line_lo, wrap_hi, wrap_lo, selftest, lo_speed, short_word;
    logic sd_en, sd_x, sd_y, sel, rd_n;
    logic [15:0] rd_data, rd_data_inv;
    logic dr_n, dr_n_inv;

    a429_rx_channel uut (
        .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
        .wrap_hi(wrap_hi), .wrap_lo(wrap_lo), .selftest(selftest), .lo_speed(lo_speed),
        .short_word(short_word), .sd_en(sd_en), .sd_x(sd_x), .sd_y(sd_y),
        .sel(sel), .rd_n(rd_n), .rd_data(rd_data), .dr_n(dr_n)
    );

    a429_rx_channel #(.INVERT_WRAP(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
        .wrap_hi(wrap_hi), .wrap_lo(wrap_lo), .selftest(selftest), .lo_speed(lo_speed),
        .short_word(short_word), .sd_en(sd_en), .sd_x(sd_x), .sd_y(sd_y),
        .sel(sel), .rd_n(rd_n), .rd_data(rd_data_inv), .dr_n(dr_n_inv)
    );

    // {expected parity flag, serial word}
    localparam logic [32:0] VEC [4] = '{
        {1'b0, 32'h6A5C_3E81},
        {1'b1, 32'hFFFF_FFFF},
        {1'b0, 32'h8000_00FF},
        {1'b1, 32'h1234_5679}
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mask_len(input logic [31:0] w, input int nbits);
        return (nbits == 25) ? (w & 32'h01FF_FFFF) : w;
    endfunction

    function automatic logic [15:0] exp_h1(input logic [31:0] w, input int nbits);
        logic [31:0] m = mask_len(w, nbits);
        return {m[14:8], ~^m, m[7:0]};
    endfunction

    function automatic logic [15:0] exp_h2(input logic [31:0] w, input int nbits);
        logic [31:0] m = mask_len(w, nbits);
        return m[30:15];
    endfunction

    task automatic set_rails(input bit to_wrap, input logic hi, input logic lo);
        if (to_wrap) begin wrap_hi = hi; wrap_lo = lo; end
        else begin line_hi = hi; line_lo = lo; end
    endtask

    task automatic send_bit(input logic b, input int half, input bit to_wrap);
        set_rails(to_wrap, b, ~b);
        step(half);
        set_rails(to_wrap, 1'b0, 1'b0);
        step(half);
    endtask

    task automatic send_word(input logic [31:0] w, input int nbits, input int half, input bit to_wrap);
        for (int k = 0; k < nbits; k++) send_bit(w[k % 32], half, to_wrap);
    endtask

    task automatic read_half(input logic s, output logic [15:0] v, output logic [15:0] vi);
        sel = s;
        step(1);
        rd_n = 1'b0;
        v  = rd_data;
        vi = rd_data_inv;
        step(1);
        rd_n = 1'b1;
        step(1);
    endtask

    task automatic expect_word(input string req, input logic [31:0] w, input int nbits);
        logic [15:0] a, ai;
        chk({req, " ready"}, {15'd0, dr_n}, 16'd0);
        read_half(1'b0, a, ai);
        chk({req, " half1"}, a, exp_h1(w, nbits));
        read_half(1'b1, a, ai);
        chk({req, " half2"}, a, exp_h2(w, nbits));
        chk({req, " ready cleared"}, {15'd0, dr_n}, 16'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, ai;
        rst_n = 1'b0; line_hi = 0; line_lo = 0; wrap_hi = 0; wrap_lo = 0;
        selftest = 0; lo_speed = 0; short_word = 0; sd_en = 0; sd_x = 0; sd_y = 0;
        sel = 0; rd_n = 1'b1;
        step(5);
        chk("R1 reset ready", {15'd0, dr_n}, 16'd1);
        rst_n = 1'b1;
        step(20);

        // R2, R4: table of words in 32-bit high-speed mode
        foreach (VEC[i]) begin
            send_word(VEC[i][31:0], 32, HI_HALF, 1'b0);
            step(25);
            chk("R2 ready", {15'd0, dr_n}, 16'd0);
            read_half(1'b0, a, ai);
            chk("R2 half1", a, exp_h1(VEC[i][31:0], 32));
            chk("R4 parity flag", {15'd0, a[8]}, {15'd0, VEC[i][32]});
            read_half(1'b1, a, ai);
            chk("R2 half2", a, exp_h2(VEC[i][31:0], 32));
            chk("R10 cleared", {15'd0, dr_n}, 16'd1);
            step(20);
        end

        // R3: 25-bit words
        short_word = 1'b1;
        step(20);
        send_word(32'h01AB_CDEF, 25, HI_HALF, 1'b0);
        step(25);
        expect_word("R3", 32'h01AB_CDEF, 25);
        short_word = 1'b0;
        step(20);

        // R10: repeated half-1 reads keep ready; completing strobe clears on its leading edge
        send_word(32'h0F0F_1234, 32, HI_HALF, 1'b0);
        step(25);
        read_half(1'b0, a, ai);
        read_half(1'b0, a, ai);
        chk("R10 same half twice keeps ready", {15'd0, dr_n}, 16'd0);
        sel = 1'b1;
        step(1);
        rd_n = 1'b0;
        step(1);
        chk("R10 cleared during strobe", {15'd0, dr_n}, 16'd1);
        rd_n = 1'b1;
        step(20);

        // R11: second word dropped while first waits
        send_word(32'hA5A5_0001, 32, HI_HALF, 1'b0);
        step(40);
        send_word(32'h5A5A_0002, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R11", 32'hA5A5_0001, 32);
        step(30);
        chk("R11 dropped word not pending", {15'd0, dr_n}, 16'd1);

        // R5: source/destination filter, x=1 y=0
        sd_en = 1'b1; sd_x = 1'b1; sd_y = 1'b0;
        send_word(32'h0000_0300, 32, HI_HALF, 1'b0);
        step(25);
        chk("R5 mismatch dropped", {15'd0, dr_n}, 16'd1);
        send_word(32'h0000_0100, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R5 match", 32'h0000_0100, 32);
        sd_en = 1'b0;
        step(20);

        // R6: word begun without a full null bit ahead
        line_hi = 1'b1;
        step(30);
        line_hi = 1'b0;
        step(5);
        send_word(32'h1357_9BDF, 32, HI_HALF, 1'b0);
        step(30);
        chk("R6 unframed word dropped", {15'd0, dr_n}, 16'd1);
        send_word(32'h2468_ACE0, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R6 recovery", 32'h2468_ACE0, 32);
        step(20);

        // R7: broken word
        send_word(32'hFFFF_FFFF, 20, HI_HALF, 1'b0);
        step(40);
        chk("R7 broken word dropped", {15'd0, dr_n}, 16'd1);
        send_word(32'h0BAD_F00D, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R7 recovery", 32'h0BAD_F00D, 32);
        step(20);

        // R8: one bit too many
        send_word(32'h7777_7777, 33, HI_HALF, 1'b0);
        step(30);
        chk("R8 long word dropped", {15'd0, dr_n}, 16'd1);
        send_word(32'h3C3C_C3C3, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R8 recovery", 32'h3C3C_C3C3, 32);
        step(20);

        // R9: short glitch rejected, following word exact
        line_hi = 1'b1;
        step(1);
        line_hi = 1'b0;
        step(30);
        send_word(32'hC001_D00D, 32, HI_HALF, 1'b0);
        step(25);
        expect_word("R9", 32'hC001_D00D, 32);
        step(20);

        // R12: low speed
        lo_speed = 1'b1;
        step(100);
        send_word(32'h9E37_79B9, 32, LO_HALF, 1'b0);
        step(200);
        expect_word("R12", 32'h9E37_79B9, 32);
        lo_speed = 1'b0;
        step(20);

        // R13: loop-back with stuck line, plain and inverted channel
        selftest = 1'b1;
        line_hi = 1'b1;
        step(20);
        send_word(32'h00C3_5A96, 32, HI_HALF, 1'b1);
        step(25);
        chk("R13 ready", {15'd0, dr_n}, 16'd0);
        chk("R13 inverted ready", {15'd0, dr_n_inv}, 16'd0);
        read_half(1'b0, a, ai);
        chk("R13 half1", a, exp_h1(32'h00C3_5A96, 32));
        chk("R13 inverted half1", ai, exp_h1(~32'h00C3_5A96, 32));
        read_half(1'b1, a, ai);
        chk("R13 half2", a, exp_h2(32'h00C3_5A96, 32));
        chk("R13 inverted half2", ai, exp_h2(~32'h00C3_5A96, 32));
        line_hi = 1'b0;
        step(20);

        // R1: reset while a word waits
        send_word(32'h1111_2222, 32, HI_HALF, 1'b1);
        step(25);
        chk("R1 word waiting", {15'd0, dr_n}, 16'd0);
        rst_n = 1'b0;
        step(2);
        chk("R1 reset clears ready", {15'd0, dr_n}, 16'd1);
        rst_n = 1'b1;
        step(5);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule